// File: doc/BRIEF.md
# Singly Linked Directory Miss Controller

This block keeps a coherence directory for a small shared-memory system in which the list of sharers for each block is stored as a singly linked chain. Memory keeps only one head pointer per block. Each cache line entry keeps its own state and a single pointer to the next (older) sharer. The controller covers the memory-side directory and the link logic of every cache. It takes miss requests from the processors and exchanges typed protocol messages with an outside network. That network carries each emitted message back into `net_msg_i`, with any delay and in any order.

A read miss makes the requester the new head. Memory either answers directly, if no cache holds the block, or redirects the request to the previous head. The previous head answers with its own identity, which becomes the requester's link. A write miss also repoints the head. The invalidation then walks the chain one cache at a time. The requester finishes its write only after it holds both the data reply from the previous head and the end-of-chain reply from the last entry. It then owns the block exclusively.

Every output message and every completion pulse is registered. It appears in the cycle after the input that caused it. At most two messages leave per cycle, on two ordered lanes.

Top module: `slink_dir_ctrl`

## Requirements
- R1: After reset no message lane is valid, `done_o` is low, and every block is uncached at memory with every cache entry invalid.
- R2: A message word is 16 bits, from MSB down: kind[15:13], source node[12:10], destination node[9:7], originating cache[6:5], block[4:3], link valid[2], link[1:0]. Kind codes: 1 read forward, 2 read reply, 3 write forward, 4 write data reply, 5 write end reply. Caches are nodes 0..3 and memory is node 4. Every output appears exactly one cycle after the request or delivered message that causes it. Lane 1 is never valid without lane 0.
- R3: A read miss on an uncached block makes memory send a read reply to the requester with link valid 0, and makes the requester the head.
- R4: A read miss on a cached block makes memory send a read forward, with the requester as originator, to the current head, and makes the requester the head.
- R5: A cache receiving a read forward sends a read reply to the originator, with link valid 1 and link equal to its own ID.
- R6: A requester waiting on a read stores the reply's link as its next pointer and pulses `done_o` with `done_write_o` low and `done_cache_o` equal to its ID.
- R7: A write miss on a cached block makes memory send a write forward to the current head and makes the requester the head.
- R8: A holder receiving a write forward from memory invalidates itself. It sends a write data reply to the originator on lane 0. On lane 1 it sends a write forward to its next entry, or a write end reply to the originator if it is the tail.
- R9: A holder receiving a write forward from another cache invalidates itself and, on lane 0 only, forwards it to its next entry or sends the write end reply if it is the tail.
- R10: A cache that does not hold the block and receives a write forward from a cache sends only a write end reply to the originator.
- R11: A write completes (`done_o` and `done_write_o` high) in the cycle after the second of the two write replies arrives, in either order. The first reply alone gives no pulse, and a reply to a cache that is not waiting produces no output.
- R12: After a write completes, the writer is the exclusive tail: a later forward to it yields a write end reply.
- R13: A write miss on an uncached block makes memory send the data reply on lane 0 and the end reply on lane 1.
- R14: Head pointers and entry states are kept per block, so a miss on one block leaves the list of another unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Miss request strobe |
| req_write_i | input | 1 | 1 for write miss, 0 for read miss |
| req_cache_i | input | 2 | Requesting cache ID |
| req_blk_i | input | 2 | Block of the miss |
| net_valid_i | input | 1 | A message is delivered this cycle |
| net_msg_i | input | 16 | Delivered message word |
| out_valid_o | output | 2 | Valid per output lane |
| out_msg0_o | output | 16 | Lane 0 message word |
| out_msg1_o | output | 16 | Lane 1 message word |
| done_o | output | 1 | A miss completed at a requester |
| done_write_o | output | 1 | The completed miss was a write |
| done_cache_o | output | 2 | Cache whose miss completed |

## Verification
The checker takes it as given that a miss request and a delivered message never arrive in the same cycle. It also assumes that a requester's entry is invalid when it misses and that at most one transaction is in flight per block. Under those conditions at most one cache agent emits in any cycle. The bench keeps to these conditions by issuing one miss at a time and delivering one captured message per cycle after the previous outputs have settled. It reorders only replies that belong to the same transaction, which is how both write-reply orders are exercised.

// File: rtl/slink_dir_pkg.sv
package slink_dir_pkg;
  parameter int unsigned NUM_CACHES = 4;
  parameter int unsigned NUM_BLOCKS = 4;

  localparam int unsigned CID_W  = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1;
  localparam int unsigned NODE_W = $clog2(NUM_CACHES + 1);
  localparam int unsigned BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam logic [NODE_W-1:0] MEM_NODE = NODE_W'(NUM_CACHES);

  typedef enum logic [2:0] {
    MK_NONE     = 3'd0,
    MK_RD_FWD   = 3'd1,
    MK_RD_REPLY = 3'd2,
    MK_WR_FWD   = 3'd3,
    MK_WR_DATA  = 3'd4,
    MK_WR_DONE  = 3'd5
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e         kind;
    logic [NODE_W-1:0] src;
    logic [NODE_W-1:0] dst;
    logic [CID_W-1:0]  orig;
    logic [BLK_W-1:0]  blk;
    logic              link_vld;
    logic [CID_W-1:0]  link;
  } msg_t;

  localparam int unsigned MSG_W = $bits(msg_t);

  typedef enum logic [2:0] {
    LS_INV     = 3'd0,
    LS_SHR     = 3'd1,
    LS_EXC     = 3'd2,
    LS_RD_WAIT = 3'd3,
    LS_WR_WAIT = 3'd4
  } line_st_e;

  function automatic msg_t mk_msg(msg_kind_e k, logic [NODE_W-1:0] s, logic [NODE_W-1:0] d,
                                  logic [CID_W-1:0] o, logic [BLK_W-1:0] b,
                                  logic lv, logic [CID_W-1:0] l);
    msg_t m;
    m.kind     = k;
    m.src      = s;
    m.dst      = d;
    m.orig     = o;
    m.blk      = b;
    m.link_vld = lv;
    m.link     = l;
    return m;
  endfunction
endpackage

// File: rtl/slink_dir_head.sv
module slink_dir_head
  import slink_dir_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [CID_W-1:0] req_cache_i,
  input  logic [BLK_W-1:0] req_blk_i,
  output msg_t             mem0_o,
  output msg_t             mem1_o
);
  logic [NUM_BLOCKS-1:0] head_vld_q;
  logic [CID_W-1:0]      head_q [NUM_BLOCKS];

  logic              old_vld;
  logic [CID_W-1:0]  old_head;
  logic [NODE_W-1:0] req_node;

  always_comb begin
    old_vld  = head_vld_q[req_blk_i];
    old_head = head_q[req_blk_i];
    req_node = NODE_W'(req_cache_i);
    mem0_o   = '0;
    mem1_o   = '0;
    if (req_valid_i) begin
      if (old_vld) begin
        mem0_o = mk_msg(req_write_i ? MK_WR_FWD : MK_RD_FWD, MEM_NODE, NODE_W'(old_head),
                        req_cache_i, req_blk_i, 1'b0, '0);
      end else if (!req_write_i) begin
        mem0_o = mk_msg(MK_RD_REPLY, MEM_NODE, req_node, req_cache_i, req_blk_i, 1'b0, '0);
      end else begin
        // no sharers: memory supplies both write replies itself
        mem0_o = mk_msg(MK_WR_DATA, MEM_NODE, req_node, req_cache_i, req_blk_i, 1'b0, '0);
        mem1_o = mk_msg(MK_WR_DONE, MEM_NODE, req_node, req_cache_i, req_blk_i, 1'b0, '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_vld_q <= '0;
      for (int i = 0; i < NUM_BLOCKS; i++) head_q[i] <= '0;
    end else if (req_valid_i) begin
      head_vld_q[req_blk_i] <= 1'b1;
      head_q[req_blk_i]     <= req_cache_i;
    end
  end
endmodule

// File: rtl/slink_cache_agent.sv
module slink_cache_agent
  import slink_dir_pkg::*;
#(
  parameter int unsigned CACHE_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [CID_W-1:0] req_cache_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             in_valid_i,
  input  msg_t             in_msg_i,
  output msg_t             out0_o,
  output msg_t             out1_o,
  output logic             done_o,
  output logic             done_wr_o
);
  localparam logic [CID_W-1:0]  MY_CID  = CID_W'(CACHE_ID);
  localparam logic [NODE_W-1:0] MY_NODE = NODE_W'(CACHE_ID);

  line_st_e              st_q  [NUM_BLOCKS];
  logic [CID_W-1:0]      nxt_q [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] nv_q, gd_q, gr_q;

  logic              hit, holds, from_mem;
  logic [BLK_W-1:0]  blk;
  logic [NODE_W-1:0] orig_node;
  line_st_e          cur;
  msg_t              chain_m;

  logic              upd;
  line_st_e          st_d;
  logic              nv_d, gd_d, gr_d;
  logic [CID_W-1:0]  nxt_d;

  always_comb begin
    hit       = in_valid_i && (in_msg_i.dst == MY_NODE);
    blk       = in_msg_i.blk;
    cur       = st_q[blk];
    holds     = (cur == LS_SHR) || (cur == LS_EXC);
    from_mem  = (in_msg_i.src == MEM_NODE);
    orig_node = NODE_W'(in_msg_i.orig);

    upd   = 1'b0;
    st_d  = cur;
    nv_d  = nv_q[blk];
    nxt_d = nxt_q[blk];
    gd_d  = gd_q[blk];
    gr_d  = gr_q[blk];

    out0_o    = '0;
    out1_o    = '0;
    done_o    = 1'b0;
    done_wr_o = 1'b0;

    // next hop of an invalidation: forward if a successor exists, else end reply
    if (holds && nv_q[blk])
      chain_m = mk_msg(MK_WR_FWD, MY_NODE, NODE_W'(nxt_q[blk]), in_msg_i.orig, blk, 1'b0, '0);
    else
      chain_m = mk_msg(MK_WR_DONE, MY_NODE, orig_node, in_msg_i.orig, blk, 1'b0, '0);

    if (hit) begin
      unique case (in_msg_i.kind)
        MK_RD_FWD: begin
          out0_o = mk_msg(MK_RD_REPLY, MY_NODE, orig_node, in_msg_i.orig, blk, 1'b1, MY_CID);
          if (cur == LS_EXC) begin
            upd  = 1'b1;
            st_d = LS_SHR;
          end
        end
        MK_WR_FWD: begin
          if (from_mem) begin
            out0_o = mk_msg(MK_WR_DATA, MY_NODE, orig_node, in_msg_i.orig, blk, 1'b0, '0);
            out1_o = chain_m;
          end else begin
            out0_o = chain_m;
          end
          if (holds) begin
            upd  = 1'b1;
            st_d = LS_INV;
            nv_d = 1'b0;
          end
        end
        MK_RD_REPLY: begin
          if (cur == LS_RD_WAIT) begin
            upd    = 1'b1;
            st_d   = LS_SHR;
            nv_d   = in_msg_i.link_vld;
            nxt_d  = in_msg_i.link;
            done_o = 1'b1;
          end
        end
        MK_WR_DATA, MK_WR_DONE: begin
          if (cur == LS_WR_WAIT) begin
            upd = 1'b1;
            if (in_msg_i.kind == MK_WR_DATA) gd_d = 1'b1;
            else                             gr_d = 1'b1;
            if (gd_d && gr_d) begin
              st_d      = LS_EXC;
              nv_d      = 1'b0;
              gd_d      = 1'b0;
              gr_d      = 1'b0;
              done_o    = 1'b1;
              done_wr_o = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        st_q[i]  <= LS_INV;
        nxt_q[i] <= '0;
      end
      nv_q <= '0;
      gd_q <= '0;
      gr_q <= '0;
    end else begin
      if (upd) begin
        st_q[blk]  <= st_d;
        nv_q[blk]  <= nv_d;
        nxt_q[blk] <= nxt_d;
        gd_q[blk]  <= gd_d;
        gr_q[blk]  <= gr_d;
      end
      if (req_valid_i && (req_cache_i == MY_CID)) begin
        st_q[req_blk_i] <= req_write_i ? LS_WR_WAIT : LS_RD_WAIT;
        nv_q[req_blk_i] <= 1'b0;
        gd_q[req_blk_i] <= 1'b0;
        gr_q[req_blk_i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slink_out_stage.sv
module slink_out_stage
  import slink_dir_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_mem_i,
  input  msg_t                  mem0_i,
  input  msg_t                  mem1_i,
  input  msg_t                  c0_i [NUM_CACHES],
  input  msg_t                  c1_i [NUM_CACHES],
  input  logic [NUM_CACHES-1:0] cdone_i,
  input  logic [NUM_CACHES-1:0] cdone_wr_i,
  output logic [1:0]            valid_o,
  output msg_t                  msg0_o,
  output msg_t                  msg1_o,
  output logic                  done_o,
  output logic                  done_wr_o,
  output logic [CID_W-1:0]      done_cache_o
);
  msg_t             m0, m1;
  logic             dn, dw;
  logic [CID_W-1:0] dc;

  always_comb begin
    m0 = sel_mem_i ? mem0_i : '0;
    m1 = sel_mem_i ? mem1_i : '0;
    dn = 1'b0;
    dw = 1'b0;
    dc = '0;
    if (!sel_mem_i) begin
      for (int i = 0; i < NUM_CACHES; i++) begin
        m0 = msg_t'(m0 | c0_i[i]);
        m1 = msg_t'(m1 | c1_i[i]);
        if (cdone_i[i]) begin
          dn = 1'b1;
          dw = cdone_wr_i[i];
          dc = CID_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= '0;
      msg0_o       <= '0;
      msg1_o       <= '0;
      done_o       <= 1'b0;
      done_wr_o    <= 1'b0;
      done_cache_o <= '0;
    end else begin
      valid_o      <= {m1.kind != MK_NONE, m0.kind != MK_NONE};
      msg0_o       <= m0;
      msg1_o       <= m1;
      done_o       <= dn;
      done_wr_o    <= dw;
      done_cache_o <= dc;
    end
  end
endmodule

// File: rtl/slink_dir_ctrl.sv
module slink_dir_ctrl
  import slink_dir_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [CID_W-1:0] req_cache_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             net_valid_i,
  input  logic [MSG_W-1:0] net_msg_i,
  output logic [1:0]       out_valid_o,
  output logic [MSG_W-1:0] out_msg0_o,
  output logic [MSG_W-1:0] out_msg1_o,
  output logic             done_o,
  output logic             done_write_o,
  output logic [CID_W-1:0] done_cache_o
);
  msg_t                  net_msg;
  msg_t                  mem0, mem1;
  msg_t                  c0 [NUM_CACHES];
  msg_t                  c1 [NUM_CACHES];
  logic [NUM_CACHES-1:0] cdone, cdone_wr, cache_emit;
  msg_t                  o0, o1;

  assign net_msg = msg_t'(net_msg_i);

  slink_dir_head u_head (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_cache_i (req_cache_i),
    .req_blk_i   (req_blk_i),
    .mem0_o      (mem0),
    .mem1_o      (mem1)
  );

  for (genvar g = 0; g < NUM_CACHES; g++) begin : g_agent
    slink_cache_agent #(.CACHE_ID(g)) u_agent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_cache_i (req_cache_i),
      .req_blk_i   (req_blk_i),
      .in_valid_i  (net_valid_i),
      .in_msg_i    (net_msg),
      .out0_o      (c0[g]),
      .out1_o      (c1[g]),
      .done_o      (cdone[g]),
      .done_wr_o   (cdone_wr[g])
    );
    assign cache_emit[g] = (c0[g].kind != MK_NONE);
  end

  slink_out_stage u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_mem_i    (req_valid_i),
    .mem0_i       (mem0),
    .mem1_i       (mem1),
    .c0_i         (c0),
    .c1_i         (c1),
    .cdone_i      (cdone),
    .cdone_wr_i   (cdone_wr),
    .valid_o      (out_valid_o),
    .msg0_o       (o0),
    .msg1_o       (o1),
    .done_o       (done_o),
    .done_wr_o    (done_write_o),
    .done_cache_o (done_cache_o)
  );

  assign out_msg0_o = o0;
  assign out_msg1_o = o1;
endmodule

// File: rtl/slink_dir_ctrl_chk.sv
module slink_dir_ctrl_chk
  import slink_dir_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  net_valid_i,
  input logic [MSG_W-1:0]      net_msg_i,
  input logic [1:0]            out_valid_i,
  input logic [MSG_W-1:0]      out_msg0_i,
  input logic                  done_i,
  input logic                  done_write_i,
  input logic [NUM_CACHES-1:0] cache_emit_i
);
  msg_t om, nm;
  assign om = msg_t'(out_msg0_i);
  assign nm = msg_t'(net_msg_i);

  assert_inputs_apart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && net_valid_i));

  assert_lane_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i[1] |-> out_valid_i[0]);

  assert_mem_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i[0] && om.src == MEM_NODE) |-> $past(req_valid_i));

  assert_cache_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i[0] && om.src != MEM_NODE) |-> $past(net_valid_i));

  assert_single_agent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cache_emit_i));

  assert_fwd_not_self_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i[0] && om.src == MEM_NODE && om.kind == MK_WR_FWD) |-> om.dst != NODE_W'(om.orig));

  assert_done_after_reply_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(net_valid_i) &&
                ($past(nm.kind) == MK_RD_REPLY || $past(nm.kind) == MK_WR_DATA ||
                 $past(nm.kind) == MK_WR_DONE)));

  assert_write_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_write_i |-> done_i);
endmodule

bind slink_dir_ctrl slink_dir_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .net_valid_i  (net_valid_i),
  .net_msg_i    (net_msg_i),
  .out_valid_i  (out_valid_o),
  .out_msg0_i   (out_msg0_o),
  .done_i       (done_o),
  .done_write_i (done_write_o),
  .cache_emit_i (cache_emit)
);

// File: tb/slink_dir_ctrl_tb.sv
`timescale 1ns/1ps
module slink_dir_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_cache = '0, req_blk = '0;
  logic        net_valid = 1'b0;
  logic [15:0] net_msg = '0;
  logic [1:0]  out_valid;
  logic [15:0] out_msg0, out_msg1;
  logic        done, done_write;
  logic [1:0]  done_cache;

  always #2 clk = ~clk;

  slink_dir_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_cache_i(req_cache), .req_blk_i(req_blk),
    .net_valid_i(net_valid), .net_msg_i(net_msg),
    .out_valid_o(out_valid), .out_msg0_o(out_msg0), .out_msg1_o(out_msg1),
    .done_o(done), .done_write_o(done_write), .done_cache_o(done_cache)
  );

  localparam int K_RDF = 1, K_RDR = 2, K_WRF = 3, K_WRD = 4, K_WRE = 5, MEM = 4;

  typedef struct {
    bit          is_done;
    logic [15:0] m;
    logic [2:0]  dv;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] net_q[$];
  int          n_chk = 0, n_fail = 0, done_cnt = 0;
  logic [15:0] mon_a;
  exp_t        mon_e;

  // R2 layout: kind, src, dst, orig, blk, link_vld, link
  function automatic logic [15:0] pk(int k, int s, int d, int o, int b, int lv, int l);
    return {3'(k), 3'(s), 3'(d), 2'(o), 2'(b), 1'(lv), 2'(l)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic e_msg(input string tag, input int k, input int s, input int d, input int o,
                       input int b, input int lv, input int l);
    exp_t e;
    e.is_done = 1'b0; e.m = pk(k, s, d, o, b, lv, l); e.dv = '0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic e_done(input string tag, input int c, input int wr);
    exp_t e;
    e.is_done = 1'b1; e.m = '0; e.dv = {1'(wr), 2'(c)}; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare every emitted item against the scoreboard and record it for the network
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 2; l++) begin
        if (out_valid[l]) begin
          mon_a = (l == 0) ? out_msg0 : out_msg1;
          net_q.push_back(mon_a);
          if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected message", 32'(mon_a), 0);
          else begin
            mon_e = exp_q.pop_front();
            chk(!mon_e.is_done && mon_e.m == mon_a, mon_e.tag, "message", 32'(mon_a), 32'(mon_e.m));
          end
        end
      end
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected done", 32'({done_write, done_cache}), 0);
        else begin
          mon_e = exp_q.pop_front();
          chk(mon_e.is_done && mon_e.dv == {done_write, done_cache}, mon_e.tag, "done",
              32'({done_write, done_cache}), 32'(mon_e.dv));
        end
      end
    end
  end

  task automatic miss(input int c, input int b, input int w);
    @(negedge clk);
    req_valid = 1'b1; req_cache = 2'(c); req_blk = 2'(b); req_write = 1'(w);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic inject(input logic [15:0] m);
    @(negedge clk);
    net_msg = m; net_valid = 1'b1;
    @(negedge clk);
    net_valid = 1'b0;
  endtask

  task automatic deliver(input int idx);
    logic [15:0] m;
    m = net_q[idx];
    net_q.delete(idx);
    inject(m);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "missing outputs", 32'(exp_q.size()), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 2'b00, "R1", "lanes idle after reset", 32'(out_valid), 0);
    chk(done == 1'b0, "R1", "done low after reset", 32'(done), 0);

    // R3: uncached read answered by memory with null link; R6 completion
    e_msg("R3", K_RDR, MEM, 0, 0, 0, 0, 0); miss(0, 0, 0); settle();
    e_done("R6", 0, 0); deliver(0); settle();

    // R4/R5/R6: C1 then C2 join block 0 -> chain 2->1->0
    e_msg("R4", K_RDF, MEM, 0, 1, 0, 0, 0); miss(1, 0, 0); settle();
    e_msg("R5", K_RDR, 0, 1, 1, 0, 1, 0); deliver(0); settle();
    e_done("R6", 1, 0); deliver(0); settle();
    e_msg("R4", K_RDF, MEM, 1, 2, 0, 0, 0); miss(2, 0, 0); settle();
    e_msg("R5", K_RDR, 1, 2, 2, 0, 1, 1); deliver(0); settle();
    e_done("R6", 2, 0); deliver(0); settle();

    // R7/R8/R9: C3 write walks the chain
    e_msg("R7", K_WRF, MEM, 2, 3, 0, 0, 0); miss(3, 0, 1); settle();
    e_msg("R8", K_WRD, 2, 3, 3, 0, 0, 0); e_msg("R8", K_WRF, 2, 1, 3, 0, 0, 0);
    deliver(0); settle();
    e_msg("R9", K_WRF, 1, 0, 3, 0, 0, 0); deliver(1); settle();
    e_msg("R9", K_WRE, 0, 3, 3, 0, 0, 0); deliver(1); settle();
    // R11: end reply first, then data
    d0 = done_cnt; deliver(1); settle();
    chk(done_cnt == d0, "R11", "no completion on first reply", 32'(done_cnt), 32'(d0));
    e_done("R11", 3, 1); deliver(0); settle();

    // R12: C3 is exclusive tail; R11 data-first order for C1
    e_msg("R7", K_WRF, MEM, 3, 1, 0, 0, 0); miss(1, 0, 1); settle();
    e_msg("R8", K_WRD, 3, 1, 1, 0, 0, 0); e_msg("R12", K_WRE, 3, 1, 1, 0, 0, 0);
    deliver(0); settle();
    d0 = done_cnt; deliver(0); settle();
    chk(done_cnt == d0, "R11", "no completion on data alone", 32'(done_cnt), 32'(d0));
    e_done("R11", 1, 1); deliver(0); settle();

    // R10: forward to a non-holder; R11: stray end reply to an idle cache is ignored
    e_msg("R10", K_WRE, 0, 3, 3, 1, 0, 0); inject(pk(K_WRF, 2, 0, 3, 1, 0, 0)); settle();
    d0 = done_cnt; deliver(0); settle();
    chk(done_cnt == d0, "R11", "stray reply ignored", 32'(done_cnt), 32'(d0));
    chk(net_q.size() == 0, "R11", "stray reply produced output", 32'(net_q.size()), 0);

    // read from exclusive owner, then write: old owner is tail (R12)
    e_msg("R4", K_RDF, MEM, 1, 2, 0, 0, 0); miss(2, 0, 0); settle();
    e_msg("R5", K_RDR, 1, 2, 2, 0, 1, 1); deliver(0); settle();
    e_done("R6", 2, 0); deliver(0); settle();
    e_msg("R7", K_WRF, MEM, 2, 0, 0, 0, 0); miss(0, 0, 1); settle();
    e_msg("R8", K_WRD, 2, 0, 0, 0, 0, 0); e_msg("R8", K_WRF, 2, 1, 0, 0, 0, 0);
    deliver(0); settle();
    e_msg("R12", K_WRE, 1, 0, 0, 0, 0, 0); deliver(1); settle();
    deliver(1); settle();
    e_done("R11", 0, 1); deliver(0); settle();

    // R13: uncached write, memory sends both replies
    e_msg("R13", K_WRD, MEM, 3, 3, 1, 0, 0); e_msg("R13", K_WRE, MEM, 3, 3, 1, 0, 0);
    miss(3, 1, 1); settle();
    deliver(1); settle();
    e_done("R13", 3, 1); deliver(0); settle();

    // R14: block heads independent (block 0 head C0, block 1 head C3)
    e_msg("R14", K_RDF, MEM, 0, 2, 0, 0, 0); miss(2, 0, 0); settle();
    e_msg("R5", K_RDR, 0, 2, 2, 0, 1, 0); deliver(0); settle();
    e_done("R6", 2, 0); deliver(0); settle();
    e_msg("R14", K_RDF, MEM, 3, 1, 1, 0, 0); miss(1, 1, 0); settle();
    e_msg("R5", K_RDR, 3, 1, 1, 1, 1, 3); deliver(0); settle();
    e_done("R14", 1, 0); deliver(0); settle();

    chk(net_q.size() == 0, "R2", "undelivered messages left", 32'(net_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule